// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Controller

This block connects a simple one-command-per-cycle request port to a synchronous SRAM that needs no turnaround cycles. A request carries an address, a write flag and the write data. It may also carry a burst flag. The controller registers the request onto the memory command pins on the next cycle. The write data is held back in a delay line, so it reaches the data bus in the slot the memory expects it. Read data is sampled from the bus in that same slot and is returned with a one-cycle valid pulse.

Each command owns exactly one data-bus slot, a fixed number of cycles after its command cycle. Because of this, reads and writes can alternate on every clock and the bus stays fully used. The parameter `PIPELINED` selects the memory timing. When it is 1, the slot is two cycles after the command. When it is 0 (flow-through), the slot is one cycle after the command. A burst read sends a first beat that carries the address. It then sends `BURST_LEN-1` further beats that ask the memory to advance its own address by one, while the request port is stalled.

Top module: `zbt_ctrl`

## Requirements
- R1: A request is accepted on a clock edge when `cmd_valid_i` and `cmd_ready_o` are both high. In the next cycle the memory pins show `mem_cs_o`=1, `mem_adv_o`=0, `mem_we_no`=0 for a write or 1 for a read, and `mem_addr_o` set to the request address. A cycle with no accepted request and no pending burst beat shows `mem_cs_o`=0.
- R2: Requests of any mix of reads and writes, presented on every cycle, are all accepted back to back. `cmd_ready_o` stays high and `mem_cs_o` is high in every following cycle, with no idle cycle at a change of direction.
- R3: With `PIPELINED`=1, a write whose command is on the pins in cycle k drives its data on `mem_dq_o` with `mem_dq_oe_o`=1 in cycle k+2. `mem_dq_oe_o` is 0 in every cycle that is not the data slot of a write.
- R4: With `PIPELINED`=0, the write data slot is cycle k+1, with the same output-enable rule as R3.
- R5: For a read command or burst beat on the pins in cycle k, the bus is sampled at the end of its data slot (k+2 when pipelined, k+1 when flow-through). `rd_valid_o` is then 1 for exactly one cycle, in the cycle after the slot, with the sampled word on `rd_data_o`. `rd_valid_o` is 0 in all other cycles.
- R6: A read accepted with `cmd_burst_i`=1 produces `BURST_LEN` consecutive command cycles. The first beat carries the address. Each later beat has `mem_cs_o`=1, `mem_we_no`=1 and `mem_adv_o`=1, and the memory then uses the previous address plus one. `cmd_ready_o` is 0 in every cycle in which a later beat is still to be issued. One `rd_valid_o` pulse is returned per beat, in address order.
- R7: A request presented while `cmd_ready_o` is 0 is ignored. It issues no memory command, and a write presented that way leaves the memory contents unchanged.
- R8: `cmd_burst_i` has no effect on a write. The write is issued as a single command, and `cmd_ready_o` stays high.
- R9: While `rst_ni` is low, the outputs are `mem_cs_o`=0, `mem_we_no`=1, `mem_adv_o`=0, `mem_dq_oe_o`=0, `rd_valid_o`=0 and `cmd_ready_o`=1.
- R10: A read issued in the cycle right after a write to the same address returns the newly written data. Results are always returned in command order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared with the memory |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Request present |
| cmd_ready_o | output | 1 | Request can be accepted this cycle |
| cmd_we_i | input | 1 | 1 = write, 0 = read |
| cmd_burst_i | input | 1 | Read burst of BURST_LEN beats |
| cmd_addr_i | input | ADDR_W | Request address |
| cmd_wdata_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | DATA_W | Read word |
| mem_cs_o | output | 1 | Memory command cycle, active high |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_adv_o | output | 1 | Memory burst advance |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data bus, driven value |
| mem_dq_oe_o | output | 1 | Data bus output enable |
| mem_dq_i | input | DATA_W | Data bus, received value |

## Verification
Two instances, one pipelined and one flow-through, receive the same stimulus. Each drives a behavioural memory with the matching latency. Single writes and reads check the command pins and show the per-mode data-slot offset. Strictly alternating write/read streams separate a correct design from one that inserts a gap or misaligns the bus direction at each change. A write followed at once by a read of the same address, burst reads with requests arriving while stalled, and burst-flagged writes cover ordering, stall handling and flag masking. A seeded random mix over a small address range then exercises read-after-write hazards.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_ADV  = 2'd3
  } op_e;

  // cycles from command on the pins to its data-bus slot
  function automatic int unsigned bus_lat(input bit pipelined);
    return pipelined ? 2 : 1;
  endfunction
endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 36,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_we_i,
  input  logic              cmd_burst_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              cmd_ready_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic [CNT_W-1:0]  left_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign cmd_ready_o = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (left_q != '0) begin
      op_q   <= OP_ADV;
      left_q <= left_q - 1'b1;
    end else if (cmd_valid_i) begin
      op_q    <= cmd_we_i ? OP_WR : OP_RD;
      addr_q  <= cmd_addr_i;
      wdata_q <= cmd_wdata_i;
      if (cmd_burst_i && !cmd_we_i) left_q <= CNT_W'(BURST_LEN - 1);
    end else begin
      op_q <= OP_NONE;
    end
  end

  assign op_o    = op_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

  generate
    if (BURST_LEN > 1) begin : g_burst_chk
      p_burst_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_ready_o && cmd_burst_i && !cmd_we_i) |=> !cmd_ready_o);
      p_stall_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_ready_o |=> (op_o == OP_ADV));
    end
  endgenerate

  p_wr_burst_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_we_i) |=> cmd_ready_o);
endmodule

// File: rtl/zbt_dline.sv
module zbt_dline #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/zbt_rcap.sv
module zbt_rcap #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_slot_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= rd_slot_i;
      if (rd_slot_i) dat_q <= dq_i;
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = dat_q;

  p_valid_from_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_slot_i));
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 36,
  parameter int unsigned BURST_LEN = 4,
  parameter bit          PIPELINED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_we_i,
  input  logic              cmd_burst_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_cs_o,
  output logic              mem_we_no,
  output logic              mem_adv_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned LAT  = bus_lat(PIPELINED);
  localparam int unsigned DL_W = DATA_W + 2;

  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_wdata;
  logic [DL_W-1:0]   bus_q;
  op_e               bus_op;
  logic [DATA_W-1:0] bus_wdata;
  logic              rd_slot;

  zbt_issue #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)
  ) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_burst_i (cmd_burst_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cmd_ready_o (cmd_ready_o),
    .op_o        (iss_op),
    .addr_o      (iss_addr),
    .wdata_o     (iss_wdata)
  );

  assign mem_cs_o   = (iss_op != OP_NONE);
  assign mem_we_no  = (iss_op != OP_WR);
  assign mem_adv_o  = (iss_op == OP_ADV);
  assign mem_addr_o = iss_addr;

  // op and write data travel to the bus slot together
  zbt_dline #(.W(DL_W), .DEPTH(LAT)) u_dline (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({iss_op, iss_wdata}),
    .q_o    (bus_q)
  );

  assign bus_op      = op_e'(bus_q[DATA_W +: 2]);
  assign bus_wdata   = bus_q[DATA_W-1:0];
  assign mem_dq_oe_o = (bus_op == OP_WR);
  assign mem_dq_o    = mem_dq_oe_o ? bus_wdata : '0;
  assign rd_slot     = (bus_op == OP_RD) || (bus_op == OP_ADV);

  zbt_rcap #(.DATA_W(DATA_W)) u_rcap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_slot_i  (rd_slot),
    .dq_i       (mem_dq_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  p_accept_issues_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=>
      (mem_cs_o && !mem_adv_o && (mem_we_no == !$past(cmd_we_i))
       && (mem_addr_o == $past(cmd_addr_i))));

  p_idle_no_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i && cmd_ready_o) |=> !mem_cs_o);

  p_wr_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cs_o && !mem_we_no) |-> ##LAT (mem_dq_oe_o && !rd_slot));

  p_oe_only_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> $past(mem_cs_o && !mem_we_no, LAT));

  p_rd_return_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cs_o && mem_we_no) |-> ##(LAT+1) rd_valid_o);
endmodule

// File: tb/zbt_mem_model.sv
module zbt_mem_model #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk,
  input  logic              cs,
  input  logic              we_n,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] dq_i
);
  logic [DATA_W-1:0] mem [2**ADDR_W];
  logic [ADDR_W-1:0] last_a;
  logic              st_rd [LAT];
  logic              st_wr [LAT];
  logic [ADDR_W-1:0] st_a  [LAT];
  logic [ADDR_W-1:0] cur_a;

  initial begin
    for (int i = 0; i < 2**ADDR_W; i++) mem[i] = '0;
    for (int i = 0; i < LAT; i++) begin
      st_rd[i] = 1'b0; st_wr[i] = 1'b0; st_a[i] = '0;
    end
    last_a = '0;
  end

  assign cur_a = adv ? last_a + 1'b1 : addr;

  always @(posedge clk) begin
    if (st_wr[LAT-1]) mem[st_a[LAT-1]] <= dq_o;
    for (int i = LAT - 1; i > 0; i--) begin
      st_rd[i] <= st_rd[i-1];
      st_wr[i] <= st_wr[i-1];
      st_a[i]  <= st_a[i-1];
    end
    st_rd[0] <= cs && we_n;
    st_wr[0] <= cs && !we_n;
    st_a[0]  <= cur_a;
    if (cs) last_a <= cur_a;
  end

  assign dq_i = st_rd[LAT-1] ? mem[st_a[LAT-1]] : '0;
endmodule

// File: tb/tb_zbt_ctrl.sv
module tb_zbt_ctrl;
  localparam int AW = 8;
  localparam int DW = 36;
  localparam int BL = 4;

  typedef struct packed {
    int            due;
    logic [DW-1:0] d;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic          c_valid = 0, c_we = 0, c_burst = 0;
  logic [AW-1:0] c_addr = '0;
  logic [DW-1:0] c_wdata = '0;

  logic p_ready, p_rv, p_cs, p_wen, p_adv, p_oe;
  logic [DW-1:0] p_rd, p_dqo, p_dqi;
  logic [AW-1:0] p_addr;
  logic f_ready, f_rv, f_cs, f_wen, f_adv, f_oe;
  logic [DW-1:0] f_rd, f_dqo, f_dqi;
  logic [AW-1:0] f_addr;

  zbt_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(BL), .PIPELINED(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(c_valid), .cmd_ready_o(p_ready),
    .cmd_we_i(c_we), .cmd_burst_i(c_burst), .cmd_addr_i(c_addr), .cmd_wdata_i(c_wdata),
    .rd_valid_o(p_rv), .rd_data_o(p_rd), .mem_cs_o(p_cs), .mem_we_no(p_wen),
    .mem_adv_o(p_adv), .mem_addr_o(p_addr), .mem_dq_o(p_dqo), .mem_dq_oe_o(p_oe),
    .mem_dq_i(p_dqi));

  zbt_mem_model #(.ADDR_W(AW), .DATA_W(DW), .LAT(2)) mem_p (
    .clk(clk), .cs(p_cs), .we_n(p_wen), .adv(p_adv), .addr(p_addr),
    .dq_o(p_dqo), .dq_i(p_dqi));

  zbt_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(BL), .PIPELINED(1'b0)) dut_ft (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(c_valid), .cmd_ready_o(f_ready),
    .cmd_we_i(c_we), .cmd_burst_i(c_burst), .cmd_addr_i(c_addr), .cmd_wdata_i(c_wdata),
    .rd_valid_o(f_rv), .rd_data_o(f_rd), .mem_cs_o(f_cs), .mem_we_no(f_wen),
    .mem_adv_o(f_adv), .mem_addr_o(f_addr), .mem_dq_o(f_dqo), .mem_dq_oe_o(f_oe),
    .mem_dq_i(f_dqi));

  zbt_mem_model #(.ADDR_W(AW), .DATA_W(DW), .LAT(1)) mem_f (
    .clk(clk), .cs(f_cs), .we_n(f_wen), .adv(f_adv), .addr(f_addr),
    .dq_o(f_dqo), .dq_i(f_dqi));

  int total = 0;
  int bad = 0;
  logic [DW-1:0] shadow [2**AW];
  ev_t wq_p[$], wq_f[$], rq_p[$], rq_f[$];
  logic mon_on = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle bus and read-return checks (R3 R4 R5)
  always @(negedge clk) if (mon_on) begin
    if (wq_p.size() > 0 && wq_p[0].due == cyc) begin
      chk("R3 pipe wr oe", 64'(p_oe), 64'd1);
      chk("R3 pipe wr data", 64'(p_dqo), 64'(wq_p[0].d));
      void'(wq_p.pop_front());
    end else chk("R3 pipe oe idle", 64'(p_oe), 64'd0);
    if (wq_f.size() > 0 && wq_f[0].due == cyc) begin
      chk("R4 flow wr oe", 64'(f_oe), 64'd1);
      chk("R4 flow wr data", 64'(f_dqo), 64'(wq_f[0].d));
      void'(wq_f.pop_front());
    end else chk("R4 flow oe idle", 64'(f_oe), 64'd0);
    if (rq_p.size() > 0 && rq_p[0].due == cyc) begin
      chk("R5 pipe rd valid", 64'(p_rv), 64'd1);
      chk("R5 pipe rd data", 64'(p_rd), 64'(rq_p[0].d));
      void'(rq_p.pop_front());
    end else chk("R5 pipe rd idle", 64'(p_rv), 64'd0);
    if (rq_f.size() > 0 && rq_f[0].due == cyc) begin
      chk("R5 flow rd valid", 64'(f_rv), 64'd1);
      chk("R5 flow rd data", 64'(f_rd), 64'(rq_f[0].d));
      void'(rq_f.pop_front());
    end else chk("R5 flow rd idle", 64'(f_rv), 64'd0);
  end

  // one request cycle; expectations follow the requirements
  task automatic step(input logic v, input logic we, input logic bu,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    c_valid = v; c_we = we; c_burst = bu; c_addr = a; c_wdata = d;
    if (v && p_ready) begin
      if (we) begin
        shadow[a] = d;
        wq_p.push_back('{due: cyc + 1 + 2, d: d});
        wq_f.push_back('{due: cyc + 1 + 1, d: d});
      end else begin
        for (int b = 0; b < (bu ? BL : 1); b++) begin
          logic [AW-1:0] ab;
          ab = a + AW'(b);
          rq_p.push_back('{due: cyc + 1 + b + 3, d: shadow[ab]});
          rq_f.push_back('{due: cyc + 1 + b + 2, d: shadow[ab]});
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0);
  endtask

  task automatic pins(input string req, input logic cs, input logic wen,
                      input logic adv, input logic [AW-1:0] a, input logic rdy);
    chk({req, " cs"}, 64'(p_cs), 64'(cs));
    chk({req, " cs ft"}, 64'(f_cs), 64'(cs));
    chk({req, " ready"}, 64'(p_ready), 64'(rdy));
    if (cs) begin
      chk({req, " we_n"}, 64'(p_wen), 64'(wen));
      chk({req, " we_n ft"}, 64'(f_wen), 64'(wen));
      chk({req, " adv"}, 64'(p_adv), 64'(adv));
      if (!adv) chk({req, " addr"}, 64'(p_addr), 64'(a));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 cs", 64'(p_cs | f_cs), 64'd0);
    chk("R9 we_n", 64'(p_wen & f_wen), 64'd1);
    chk("R9 adv", 64'(p_adv | f_adv), 64'd0);
    chk("R9 oe", 64'(p_oe | f_oe), 64'd0);
    chk("R9 rd_valid", 64'(p_rv | f_rv), 64'd0);
    chk("R9 ready", 64'(p_ready & f_ready), 64'd1);
  endtask

  task automatic t_single;
    step(1, 1, 0, 8'h11, 36'h0_1234_5678);
    step(0, 0, 0, '0, '0);
    pins("R1 write", 1, 0, 0, 8'h11, 1);
    step(1, 0, 0, 8'h11, '0);
    pins("R1 idle", 0, 1, 0, '0, 1);
    step(0, 0, 0, '0, '0);
    pins("R1 read", 1, 1, 0, 8'h11, 1);
    idle(5);
  endtask

  task automatic t_alternate;
    for (int i = 0; i < 16; i++) begin
      step(1, (i % 2) == 0, 0, AW'(8'h20 + (i / 2)), DW'(36'hA_0000_0000 + i));
      if (i > 0) pins("R2 back-to-back", 1, (i % 2) == 0, 0, AW'(8'h20 + ((i - 1) / 2)), 1);
    end
    step(0, 0, 0, '0, '0);
    pins("R2 last", 1, 1, 0, 8'h27, 1);
    idle(5);
  endtask

  task automatic t_raw;
    step(1, 1, 0, 8'h33, 36'h5_5555_0001);
    step(1, 0, 0, 8'h33, '0);   // R10 read right after write
    step(1, 1, 0, 8'h33, 36'h5_5555_0002);
    step(1, 0, 0, 8'h33, '0);
    idle(6);
  endtask

  task automatic t_burst;
    for (int i = 0; i < BL; i++) step(1, 1, 0, AW'(8'h40 + i), DW'(36'hB_0000_0040 + i));
    step(1, 1, 0, 8'h50, 36'h7_0000_0050);
    step(1, 0, 1, 8'h40, '0);
    step(1, 1, 0, 8'h50, 36'hD_EAD0_0000);   // R7 offered while stalled
    pins("R6 beat0", 1, 1, 0, 8'h40, 0);
    step(1, 1, 0, 8'h50, 36'hD_EAD0_0001);
    pins("R6 beat1", 1, 1, 1, '0, 0);
    step(0, 0, 0, '0, '0);
    pins("R6 beat2", 1, 1, 1, '0, 0);
    step(1, 0, 0, 8'h50, '0);
    pins("R6 beat3", 1, 1, 1, '0, 1);
    step(0, 0, 0, '0, '0);
    pins("R7 stalled write dropped", 1, 1, 0, 8'h50, 1);
    idle(6);
  endtask

  task automatic t_wr_burst;
    step(1, 1, 1, 8'h60, 36'hC_0000_0060);
    step(0, 0, 0, '0, '0);
    pins("R8 burst flag on write", 1, 0, 0, 8'h60, 1);
    step(0, 0, 0, '0, '0);
    pins("R8 single command", 0, 1, 0, '0, 1);
    step(1, 0, 0, 8'h60, '0);
    step(1, 0, 0, 8'h61, '0);
    idle(6);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic v, we, bu;
      v  = ($urandom_range(0, 9) != 0);
      we = $urandom_range(0, 1) == 1;
      bu = ($urandom_range(0, 7) == 0);
      step(v, we, bu, AW'($urandom_range(0, 15)), DW'({$urandom, 4'h0}) + DW'(i));
    end
    idle(8);
    chk("R10 all writes drained", 64'(wq_p.size() + wq_f.size()), 64'd0);
    chk("R10 all reads returned", 64'(rq_p.size() + rq_f.size()), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) shadow[i] = '0;
    void'($urandom(32'h2f1d));
    repeat (3) @(negedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    t_single;
    t_alternate;
    t_raw;
    t_burst;
    t_wr_burst;
    t_random;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule